// File: doc/BRIEF.md
# Fractional Nanosecond Baud Generator

This block turns a fixed functional clock into the oversampling strobe and the bit strobe that a serial transmitter and receiver use. Software does not program a clock count. It programs the length of one sample period in nanoseconds: an integer part plus a fraction counted in 255ths of a nanosecond. Each clock cycle advances an accumulator by the clock period, kept in the same 1/255 ns units. When the accumulated time reaches one sample period, a sample strobe is issued and one period is taken off the accumulator. The rounding error therefore never builds up, and the average strobe rate matches the programmed period exactly.

A second register selects how many sample strobes make up one bit. Normal rates use sixteen; rates of 4 Mbit/s and above use eight. Two keyed 32-bit values select the ratio, and any value other than the sixteen-key falls back to eight. The block sits beside the serial shifters. Register decoding happens upstream: this block sees only a write strobe, a one-bit register select and the data word.

Top module: `nsbaud_gen`

## Requirements
- R1: While `rst_n` is low both strobes are low. After reset the period defaults to integer 500 ns with zero fraction, and the ratio defaults to sixteen; counting starts at the first clock edge after reset is released.
- R2: The period word written with `wr_addr`=0 holds the integer nanoseconds in bits 31:8 and the fraction in bits 7:0, in units of 1/255 ns. The sample period is I + F/255 ns.
- R3: Each clock cycle counts as 16 ns of elapsed time. Number the clock edges n = 1, 2, … from the restart point. The edges that register a `sample_tick` pulse are exactly those where floor(n·16·255 / (255·I+F)) rises.
- R4: The clock edge that takes a period write clears the accumulator and the bit counter, and both strobes are low after that edge. Numbering restarts, so the next edge is n=1.
- R5: When the integer part is below 16, `sample_tick` is high after every clock edge except the edge that takes a period write.
- R6: Writing 0x6EF71000 with `wr_addr`=1 selects a ratio of sixteen. After the next period write, `bit_tick` rises with every 16th sample strobe.
- R7: Writing 0x26731000 with `wr_addr`=1 selects a ratio of eight. After the next period write, `bit_tick` rises with every 8th sample strobe.
- R8: Any other value written with `wr_addr`=1 selects a ratio of eight.
- R9: `bit_tick` is high only in cycles where `sample_tick` is also high.
- R10: A write with `wr_addr`=1 does not disturb the sample schedule. The edge that takes the write is an ordinary counted edge, and the sample strobes continue as if no write had occurred.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock, nominally 62.5 MHz |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_addr | input | 1 | 0 selects the period register, 1 selects the ratio register |
| wr_data | input | 32 | Write data |
| sample_tick | output | 1 | Oversampling strobe |
| bit_tick | output | 1 | Strobe at the end of each bit time |

## Verification
The assertions take for granted that a write strobe lasts one cycle. They also assume that the bit counter is judged only after the ratio has been settled by a period write, since a ratio change in mid-bit leaves the phase of the next bit strobe open. The stimulus always writes the ratio before the period. While the ratio changes it checks only the sample strobe, and it resumes checking the bit strobe from the next period write. Periods are drawn around the clamp boundary of 16 ns and well above it, so that the no-back-to-back property for long periods and the one-strobe-per-clock property for short ones are both exercised.

// File: rtl/nsbaud_gen.sv
module nsbaud_gen #(
  parameter int          CLK_NS     = 16,
  parameter logic [31:0] RST_DIV    = 32'h0001_F400,
  parameter logic [31:0] KEY_X16    = 32'h6EF7_1000,
  parameter logic [31:0] KEY_X8     = 32'h2673_1000,
  parameter logic [31:0] RST_MODE   = 32'h6EF7_1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_addr,
  input  logic [31:0] wr_data,
  output logic        sample_tick,
  output logic        bit_tick
);
  localparam int AW   = 34;
  localparam int STEP = CLK_NS * 255;

  logic [31:0]   div_q;
  logic          x16_q;
  logic [AW-1:0] acc_q;
  logic [3:0]    sub_q;

  logic [AW-1:0] period, sum;
  logic          fast, hit, last, div_wr, mode_wr;

  assign div_wr  = wr_en && !wr_addr;
  assign mode_wr = wr_en && wr_addr;
  assign period  = ({10'd0, div_q[31:8]} * 34'd255) + {26'd0, div_q[7:0]};
  assign sum     = acc_q + AW'(STEP);
  assign fast    = div_q[31:8] < 24'(CLK_NS);
  assign hit     = fast || (sum >= period);
  assign last    = x16_q ? (sub_q == 4'd15) : (sub_q >= 4'd7);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q       <= RST_DIV;
      x16_q       <= (RST_MODE == KEY_X16);
      acc_q       <= '0;
      sub_q       <= '0;
      sample_tick <= 1'b0;
      bit_tick    <= 1'b0;
    end else if (div_wr) begin
      div_q       <= wr_data;
      acc_q       <= '0;
      sub_q       <= '0;
      sample_tick <= 1'b0;
      bit_tick    <= 1'b0;
    end else begin
      if (mode_wr) x16_q <= (wr_data == KEY_X16);
      sample_tick <= hit;
      bit_tick    <= hit && last;
      if (hit) begin
        acc_q <= fast ? '0 : sum - period;
        sub_q <= last ? 4'd0 : sub_q + 4'd1;
      end else begin
        acc_q <= sum;
      end
    end
  end
endmodule

// File: rtl/nsbaud_gen_chk.sv
module nsbaud_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        wr_addr,
  input logic [31:0] div_q,
  input logic        sample_tick,
  input logic        bit_tick
);
  logic short_p, long_p, div_wr;
  assign short_p = div_q[31:8] < 24'd16;
  assign long_p  = div_q[31:8] >= 24'd32;
  assign div_wr  = wr_en && !wr_addr;

  AST_BIT_WITH_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sample_tick); // R9

  AST_QUIET_AFTER_DIV_WR: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr |=> (!sample_tick && !bit_tick)); // R4

  AST_CLAMP_EVERY_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (short_p && !div_wr) |=> sample_tick); // R5

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (long_p && sample_tick) |=> !sample_tick); // R3

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!sample_tick && !bit_tick)); // R1
endmodule

bind nsbaud_gen nsbaud_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .div_q(div_q), .sample_tick(sample_tick), .bit_tick(bit_tick)
);

// File: tb/nsbaud_gen_test.sv
module nsbaud_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic wr_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic sample_tick, bit_tick;

  int total = 0;
  int bad = 0;
  longint n = 0;
  longint cur_int = 500;
  longint cur_frac = 0;
  int ratio = 16;
  int pend_ratio = 16;
  bit bit_ok = 1'b1;
  int sticks = 0;
  int bticks = 0;

  always #5 clk = ~clk;

  nsbaud_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sample_tick(sample_tick), .bit_tick(bit_tick)
  );

  function automatic longint eff_period(longint i, longint f);
    if (i < 16) return 16 * 255;
    return i * 255 + f;
  endfunction

  function automatic longint tick_count(longint cyc, longint i, longint f);
    return (cyc * 16 * 255) / eff_period(i, f);
  endfunction

  task automatic check(string req, logic got, logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s n=%0d got=%b exp=%b", req, n, got, exp);
    end
  endtask

  task automatic step(string req);
    longint k0, k1;
    bit es, eb;
    @(posedge clk);
    @(negedge clk);
    n++;
    k0 = tick_count(n - 1, cur_int, cur_frac);
    k1 = tick_count(n, cur_int, cur_frac);
    es = (k1 != k0);
    eb = es && ((k1 % ratio) == 0);
    check(req, sample_tick, es);
    if (bit_ok) check(req, bit_tick, eb);
    if (sample_tick) sticks++;
    if (bit_tick) bticks++;
  endtask

  task automatic write_div(longint i, longint f);
    wr_en = 1'b1; wr_addr = 1'b0; wr_data = {i[23:0], f[7:0]};
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    check("R4", sample_tick, 1'b0);
    check("R4", bit_tick, 1'b0);
    cur_int = i; cur_frac = f; n = 0;
    ratio = pend_ratio; bit_ok = 1'b1;
  endtask

  task automatic write_mode(logic [31:0] v);
    pend_ratio = (v == 32'h6EF7_1000) ? 16 : 8;
    bit_ok = 1'b0;
    wr_en = 1'b1; wr_addr = 1'b1; wr_data = v;
    step("R10");
    wr_en = 1'b0;
  endtask

  task automatic run(string req, int cycles);
    for (int c = 0; c < cycles; c++) step(req);
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) begin
      @(negedge clk);
      check("R1", sample_tick, 1'b0);
      check("R1", bit_tick, 1'b0);
    end
    rst_n = 1'b1;
    // R1 defaults: 500 ns, ratio sixteen
    run("R1", 1100);
    check("R6", logic'(bticks == 2), 1'b1);

    // R5 clamp and R3 boundary around 16 ns
    write_mode(32'h2673_1000);
    write_div(15, 255);
    run("R5", 40);
    write_div(0, 0);
    run("R5", 20);
    write_div(16, 0);
    run("R3", 40);
    write_div(16, 1);
    run("R3", 300);
    // R2 fraction weight: 16+255/255 = 17 ns
    write_div(16, 255);
    sticks = 0;
    run("R2", 170);
    check("R2", logic'(sticks == 160), 1'b1);

    // R7 and R6 directed
    write_div(33, 128);
    run("R7", 400);
    write_mode(32'h6EF7_1000);
    write_div(20, 77);
    run("R6", 500);
    // R8 near-miss key
    write_mode(32'h6EF7_1001);
    write_div(24, 10);
    run("R8", 400);

    // R10 ratio write in mid-stream
    write_div(50, 200);
    run("R10", 37);
    write_mode(32'h2673_1000);
    run("R10", 200);

    for (int it = 0; it < 40; it++) begin
      int sel;
      logic [31:0] mv;
      longint ri, rf;
      sel = $urandom_range(0, 2);
      mv = (sel == 0) ? 32'h6EF7_1000 : (sel == 1) ? 32'h2673_1000 : $urandom();
      write_mode(mv);
      run("R10", $urandom_range(1, 10));
      ri = (($urandom_range(0, 3) == 0) ? longint'($urandom_range(0, 20))
                                       : longint'($urandom_range(16, 400)));
      rf = longint'($urandom_range(0, 255));
      write_div(ri, rf);
      run((sel == 0) ? "R6" : (sel == 1) ? "R7" : "R8", 600);
      run("R3", 50);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule